// File: doc/BRIEF.md
# Performance Counter Access Permission Checker

This unit decides, in the same cycle as the decode, whether a read of one of the user-visible performance counter CSRs may go ahead or must be turned into an illegal-instruction exception. It looks at the 12-bit CSR address, the current privilege level, whether the hart runs in a virtualized guest, whether the hart is in 32-bit mode, and two 32-bit counter-enable masks: one owned by machine mode and one owned by the hypervisor.

The counter space holds two windows of 32 addresses. The low window, 0xC00 to 0xC1F, holds the cycle counter at offset 0, the real-time counter at offset 1, the retired-instruction counter at offset 2 and the hardware event counters 3 to 31 at the matching offsets. The high window, 0xC80 to 0xC9F, holds the upper 32 bits of the same counters in the same order. The offset of an address inside its window selects one bit of each enable mask. Machine mode reads freely. Lower privileges need the machine bit, and inside a guest they also need the hypervisor bit. The high window exists only in 32-bit mode.

The block is purely combinational, with no clock or reset. Its two outputs feed the decode stage's exception logic. All pins are plain control and status signals, and none of them uses a handshake.

Top module: `pmc_access_check`

## Requirements
- R1: `ctr_hit` is 1 exactly when `csr_addr` lies in 0xC00..0xC1F or 0xC80..0xC9F, and is 0 for every other address.
- R2: When `ctr_hit` is 0, `illegal` is 0 whatever the other inputs are.
- R3: At machine privilege (`priv` = 2'b11), no access to the low window is flagged, and no access to the high window is flagged in 32-bit mode. This holds for any enable masks and any `virt_on` value.
- R4: At supervisor (`priv` = 2'b01) or user (`priv` = 2'b00) privilege, a low-window access is flagged when bit (`csr_addr` - 0xC00) of `mcnt_en` is 0. Bit 0 gates cycle, bit 1 gates time and bit 2 gates retired instructions.
- R5: In 32-bit mode (`rv32` = 1), a high-window access below machine privilege is flagged when bit (`csr_addr` - 0xC80) of `mcnt_en` is 0.
- R6: In 64-bit mode (`rv32` = 0), every high-window access is flagged, at any privilege.
- R7: With `virt_on` = 1 and privilege below machine, an access is also flagged when the `hcnt_en` bit at the same window offset is 0. This check adds to the machine check and never relaxes it.
- R8: With `virt_on` = 0, `hcnt_en` has no effect on `illegal`.
- R9: The reserved privilege code 2'b10 is treated like a privilege below machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | CSR address of the read |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt_on | input | 1 | Hart runs in a virtualized guest |
| rv32 | input | 1 | 1 = 32-bit mode, 0 = 64-bit mode |
| mcnt_en | input | 32 | Machine counter-enable mask |
| hcnt_en | input | 32 | Hypervisor counter-enable mask |
| ctr_hit | output | 1 | Address lies in a counter window |
| illegal | output | 1 | Read must raise illegal instruction |

## Verification
The machine-mask gate and the hypervisor-mask gate can both refuse the same access. In 64-bit mode, the high-window rejection can also coincide with either gate. The sweep pairs enable patterns in which both masks are clear, only one is clear, or both are set at the same offset. It runs each pattern at every privilege and in both widths, and it judges the outcome against an expected value built as the OR of the independent refusal reasons. Any masking or wrong ordering between the gates therefore shows up as a mismatch.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  parameter int ADDR_W = 12;
  parameter int CNT_N  = 32;
  localparam int IDX_W = $clog2(CNT_N);
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [ADDR_W-1:0] LO_BASE = 12'hC00;
  localparam logic [ADDR_W-1:0] HI_BASE = 12'hC80;
  localparam logic [TAG_W-1:0]  LO_TAG  = LO_BASE[ADDR_W-1:IDX_W];
  localparam logic [TAG_W-1:0]  HI_TAG  = HI_BASE[ADDR_W-1:IDX_W];

  typedef enum logic [1:0] {
    PL_USER = 2'b00,
    PL_SUP  = 2'b01,
    PL_RSVD = 2'b10,
    PL_MACH = 2'b11
  } priv_e;

  typedef struct packed {
    logic             lo;
    logic             hi;
    logic [IDX_W-1:0] idx;
  } win_t;
endpackage

// File: rtl/pmc_addr_decode.sv
module pmc_addr_decode
  import pmc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output win_t              win
);
  always_comb begin
    win.lo  = (addr[ADDR_W-1:IDX_W] == LO_TAG);
    win.hi  = (addr[ADDR_W-1:IDX_W] == HI_TAG);
    win.idx = addr[IDX_W-1:0];
  end
endmodule

// File: rtl/pmc_bit_pick.sv
module pmc_bit_pick
  import pmc_pkg::*;
(
  input  logic [CNT_N-1:0] mask,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  logic [CNT_N-1:0] sel;
  genvar g;
  generate
    for (g = 0; g < CNT_N; g++) begin : g_sel
      assign sel[g] = mask[g] && (idx == IDX_W'(g));
    end
  endgenerate
  assign bit_o = |sel;
endmodule

// File: rtl/pmc_priv_gate.sv
module pmc_priv_gate
  import pmc_pkg::*;
(
  input  win_t        win,
  input  logic [1:0]  priv,
  input  logic        virt_on,
  input  logic        rv32,
  input  logic        m_bit,
  input  logic        h_bit,
  output logic        hit,
  output logic        deny
);
  logic below_m, wide_hi, m_deny, h_deny;
  always_comb begin
    hit     = win.lo || win.hi;
    below_m = (priv != PL_MACH);
    wide_hi = win.hi && !rv32;
    m_deny  = below_m && !m_bit;
    h_deny  = below_m && virt_on && !h_bit;
    deny    = hit && (wide_hi || m_deny || h_deny);
  end
endmodule

// File: rtl/pmc_access_check.sv
module pmc_access_check
  import pmc_pkg::*;
(
  input  logic [11:0] csr_addr,
  input  logic [1:0]  priv,
  input  logic        virt_on,
  input  logic        rv32,
  input  logic [31:0] mcnt_en,
  input  logic [31:0] hcnt_en,
  output logic        ctr_hit,
  output logic        illegal
);
  win_t win;
  logic m_bit, h_bit;

  pmc_addr_decode u_dec (.addr(csr_addr), .win(win));
  pmc_bit_pick u_mpick (.mask(mcnt_en), .idx(win.idx), .bit_o(m_bit));
  pmc_bit_pick u_hpick (.mask(hcnt_en), .idx(win.idx), .bit_o(h_bit));
  pmc_priv_gate u_gate (
    .win(win), .priv(priv), .virt_on(virt_on), .rv32(rv32),
    .m_bit(m_bit), .h_bit(h_bit), .hit(ctr_hit), .deny(illegal)
  );
endmodule

// File: rtl/pmc_access_check_chk.sv
module pmc_access_check_chk (
  input logic [11:0] csr_addr,
  input logic [1:0]  priv,
  input logic        virt_on,
  input logic        rv32,
  input logic [31:0] mcnt_en,
  input logic [31:0] hcnt_en,
  input logic        ctr_hit,
  input logic        illegal
);
  logic in_lo, in_hi;
  logic [4:0] off;
  always_comb begin
    in_lo = (csr_addr >= 12'hC00) && (csr_addr <= 12'hC1F);
    in_hi = (csr_addr >= 12'hC80) && (csr_addr <= 12'hC9F);
    off   = in_hi ? 5'(csr_addr - 12'hC80) : 5'(csr_addr - 12'hC00);
  end

  always_comb begin
    if (!$isunknown({csr_addr, priv, virt_on, rv32, mcnt_en, hcnt_en, ctr_hit, illegal})) begin
      assert_quiet_outside_R2: assert (ctr_hit || !illegal);
      assert_machine_open_R3: assert (!(priv == 2'b11 && (in_lo || (in_hi && rv32))) || !illegal);
      assert_mgate_R4: assert (!(in_lo && priv != 2'b11 && !mcnt_en[off]) || illegal);
      assert_wide_upper_R6: assert (!(in_hi && !rv32) || illegal);
      assert_virt_gate_R7: assert (!((in_lo || in_hi) && virt_on && priv != 2'b11 && !hcnt_en[off]) || illegal);
    end
  end
endmodule

bind pmc_access_check pmc_access_check_chk u_chk (.*);

// File: tb/pmc_access_check_tb.sv
module pmc_access_check_tb;
  logic clk = 0;
  always #4 clk = ~clk;

  logic [11:0] csr_addr = '0;
  logic [1:0]  priv = 2'b11;
  logic        virt_on = 0, rv32 = 1;
  logic [31:0] mcnt_en = '0, hcnt_en = '0;
  logic        ctr_hit, illegal;
  int errs = 0, checks = 0;
  bit done = 0;

  pmc_access_check u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s addr=%h priv=%0d virt=%0b rv32=%0b act=%0b exp=%0b",
               req, csr_addr, priv, virt_on, rv32, act, exp);
    end
  endtask

  task automatic run_one(input logic [11:0] a, input logic [1:0] p, input logic v,
                         input logic w, input logic [31:0] m, input logic [31:0] h);
    logic lo, hi, below, eh, ei;
    int off;
    @(negedge clk);
    csr_addr = a; priv = p; virt_on = v; rv32 = w; mcnt_en = m; hcnt_en = h;
    #1;
    lo = (a >= 12'hC00) && (a <= 12'hC1F);
    hi = (a >= 12'hC80) && (a <= 12'hC9F);
    off = hi ? int'(a) - 'hC80 : int'(a) - 'hC00;
    below = (p != 2'b11);
    eh = lo || hi;
    ei = eh && ((hi && !w) || (below && !m[off]) || (below && v && !h[off]));
    chk("R1", ctr_hit, eh);
    if (!eh) chk("R2", illegal, 1'b0);
    else if (hi && !w) chk("R6", illegal, 1'b1);
    else if (!below) chk("R3", illegal, 1'b0);
    else if (p == 2'b10) chk("R9", illegal, ei);
    else if (v) chk("R7", illegal, ei);
    else if (hi) chk("R5", illegal, ei);
    else chk("R4", illegal, ei);
  endtask

  initial begin
    logic [31:0] mm [5];
    logic [31:0] hm [5];
    logic [11:0] outs [7];
    mm = '{32'hFFFF_FFFF, 32'h0, 32'hAAAA_5555, 32'h55AA_33CC, 32'hFFFF_FFFF};
    hm = '{32'hFFFF_FFFF, 32'h0, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h1234_5678};
    outs = '{12'hBFF, 12'hC20, 12'hC7F, 12'hCA0, 12'h000, 12'hFFF, 12'hC40};
    #2;
    chk("R1 idle", ctr_hit, 1'b0);
    chk("R2 idle", illegal, 1'b0);
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 4; p++)
        for (int v = 0; v < 2; v++)
          for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < 32; i++) begin
              run_one(12'hC00 + 12'(i), 2'(p), v[0], w[0], mm[k], hm[k]);
              run_one(12'hC80 + 12'(i), 2'(p), v[0], w[0], mm[k], hm[k]);
            end
            for (int o = 0; o < 7; o++)
              run_one(outs[o], 2'(p), v[0], w[0], mm[k], hm[k]);
          end
    // R8: hypervisor mask without virtualization has no effect
    run_one(12'hC05, 2'b01, 1'b0, 1'b1, 32'h20, 32'h0);
    chk("R8", illegal, 1'b0);
    // R4 named counters: time blocked, instret allowed
    run_one(12'hC01, 2'b00, 1'b0, 1'b1, 32'h5, 32'h0);
    chk("R4 time", illegal, 1'b1);
    run_one(12'hC02, 2'b00, 1'b0, 1'b1, 32'h4, 32'h0);
    chk("R4 instret", illegal, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule